// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers a small set of shared, level-sensitive PCI interrupt lines onto the inputs of a legacy interrupt controller. Each shared line has one routing byte. Configuration software writes that byte through a byte-enabled register write port. A routing value below the number of controller inputs names the target input. Any larger value takes the line out of the routing.

Internally the block keeps one bit per (target, line) pair. An output is the OR of every line currently routed to it, so several devices can share one controller input. When a single line changes level, only its own bit at its current target is updated. When software rewrites any routing byte, the whole bit map is rebuilt from the present line levels. The new routing therefore takes effect on lines that are already asserted.

A separate combinational path converts a device's interrupt pin and its device/function number into the index of the shared line that pin drives on the board. It uses the usual slot rotation.

Top module: `intline_router`

## Requirements
- R1: The routing byte of shared line p lives at configuration byte offset 0x60+p. With the defaults these are offsets 0x60 to 0x63. A read of the aligned 32-bit word at `cfg_rd_addr` returns, in byte lane b, the routing byte at word base + b. A lane that maps to no routing byte reads 0.
- R2: A routing value in the range 0 to 15 steers its line to `irq_out` bit [value]. A value of 16 or more (for example 0x10, 0x80 or 0xFF) makes that line drive no output.
- R3: While `rst` is high at a clock edge, every routing byte becomes 0x80 and `irq_out` becomes all zero.
- R4: `irq_out[k]` is high when at least one line routed to k is high. Two lines routed to the same output keep it high until both are low.
- R5: A change of `pirq_lvl` sampled at a clock edge appears on `irq_out` right after that edge and not before. Outputs with no affected line keep their value.
- R6: A write that changes routing rebuilds the map at the same edge. A line that is high moves from its old output to its new one right after the write edge.
- R7: Byte lane b of a write updates only when `cfg_wr_be[b]` is set. One write with several enabled lanes updates all the covered routing bytes at the same edge.
- R8: Writes whose enabled lanes touch no routing offset leave the routing bytes and `irq_out` unchanged.
- R9: `dev_pirq` = (`dev_pin` + `dev_fn[7:3]` − 1) mod 4, where `dev_pin` 0 to 3 stands for INTA to INTD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pirq_lvl | input | 4 | Level of each shared interrupt line |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Byte address of the write; low two bits select nothing |
| cfg_wr_data | input | 32 | Write data, lane b in bits 8b+7..8b |
| cfg_wr_be | input | 4 | Per-lane byte enables |
| cfg_rd_addr | input | 8 | Byte address of the read-back word |
| cfg_rd_data | output | 32 | Routing bytes of the addressed word, combinational |
| dev_fn | input | 8 | Device/function number; bits 7..3 are the slot |
| dev_pin | input | 2 | Device interrupt pin, 0 = INTA to 3 = INTD |
| dev_pirq | output | 2 | Shared line index driven by that pin |
| irq_out | output | 16 | Level outputs to the interrupt controller |

## Verification
On every cycle, the assertions hold the registered outputs equal to the OR of the last sampled levels over the current routes. They also check that a routing byte with no enabled lane aimed at it keeps its value, and that reset clears both routes and outputs. The embedded checks cannot show when a change appears or how a rebuild plays out against earlier incremental updates. The bench's reference model covers these by comparing every cycle, through directed cases: a route moved under an asserted line, two lines sharing an output, the route boundary values 15 and 16, partial byte enables and writes to neighbouring offsets. A randomized phase follows, and then a sweep of all slots and pins for the rotation.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int unsigned ROUTE_W = 8;
   typedef logic [ROUTE_W-1:0] route_t;
   // reset value: above any valid target, so the line is parked
   localparam route_t ROUTE_PARKED = 8'h80;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 4,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned BUS_BYTES  = 4,
   parameter int unsigned ROUTE_BASE = 'h60
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [8*BUS_BYTES-1:0]        wr_data,
   input  logic [BUS_BYTES-1:0]          wr_be,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [8*BUS_BYTES-1:0]        rd_data,
   output route_t [NUM_LINES-1:0]        route_q,
   output route_t [NUM_LINES-1:0]        route_d,
   output logic                          route_wr
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BUS_BYTES - 1);

   logic [ADDR_W-1:0]    wr_base;
   logic [ADDR_W-1:0]    rd_base;
   logic [NUM_LINES-1:0] hit;

   assign wr_base = wr_addr & ALIGN_MASK;
   assign rd_base = rd_addr & ALIGN_MASK;

   for (genvar p = 0; p < NUM_LINES; p++) begin : g_line
      localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(ROUTE_BASE + p);

      always_comb begin
         hit[p]     = 1'b0;
         route_d[p] = route_q[p];
         for (int b = 0; b < BUS_BYTES; b++) begin
            if (wr_en && wr_be[b] && (wr_base + ADDR_W'(b)) == MY_OFF) begin
               hit[p]     = 1'b1;
               route_d[p] = wr_data[8*b +: 8];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (rst) route_q[p] <= ROUTE_PARKED;
         else     route_q[p] <= route_d[p];
      end

      // lanes not enabled for this byte never disturb it
      assert_be_gate_R7: assert property (@(posedge clk) disable iff (rst)
         !hit[p] |=> $stable(route_q[p]));

      assert_reset_route_R3: assert property (@(posedge clk)
         rst |=> route_q[p] == ROUTE_PARKED);
   end

   assign route_wr = |hit;

   for (genvar b = 0; b < BUS_BYTES; b++) begin : g_rd_lane
      always_comb begin
         rd_data[8*b +: 8] = '0;
         for (int p = 0; p < NUM_LINES; p++) begin
            if ((rd_base + ADDR_W'(b)) == ADDR_W'(ROUTE_BASE + p))
               rd_data[8*b +: 8] = route_q[p];
         end
      end
   end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 4,
   parameter int unsigned NUM_TARGETS = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_LINES-1:0]     lvl_in,
   input  route_t [NUM_LINES-1:0]   route_q,
   input  route_t [NUM_LINES-1:0]   route_d,
   input  logic                     route_wr,
   output logic [NUM_TARGETS-1:0]   irq_q
);
   localparam int unsigned MAP_W   = NUM_LINES * NUM_TARGETS;
   localparam int unsigned MAP_IW  = $clog2(MAP_W);
   localparam int unsigned TGT_W   = $clog2(NUM_TARGETS);
   localparam logic [ROUTE_W:0] TGT_LIM = (ROUTE_W+1)'(NUM_TARGETS);

   logic [NUM_LINES-1:0] lvl_q;
   logic [MAP_W-1:0]     map_q;
   logic [MAP_W-1:0]     map_d;

   // next map: full rebuild after a routing write, else per-line patch
   always_comb begin
      map_d = map_q;
      if (route_wr) begin
         map_d = '0;
         for (int p = 0; p < NUM_LINES; p++) begin
            if ({1'b0, route_d[p]} < TGT_LIM)
               map_d[MAP_IW'(int'(route_d[p]) * NUM_LINES + p)] = lvl_in[p];
         end
      end else begin
         for (int p = 0; p < NUM_LINES; p++) begin
            if (lvl_in[p] != lvl_q[p] && {1'b0, route_q[p]} < TGT_LIM)
               map_d[MAP_IW'(int'(route_q[p]) * NUM_LINES + p)] = lvl_in[p];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         map_q <= '0;
         lvl_q <= '0;
      end else begin
         map_q <= map_d;
         lvl_q <= lvl_in;
      end
   end

   for (genvar k = 0; k < NUM_TARGETS; k++) begin : g_out
      always_ff @(posedge clk) begin
         if (rst) irq_q[k] <= 1'b0;
         else     irq_q[k] <= |map_d[k*NUM_LINES +: NUM_LINES];
      end
   end

   // independent fold of last sampled levels over the live routes
   logic [NUM_TARGETS-1:0] fold_exp;
   logic                   all_parked;
   always_comb begin
      fold_exp   = '0;
      all_parked = 1'b1;
      for (int p = 0; p < NUM_LINES; p++) begin
         if ({1'b0, route_q[p]} < TGT_LIM) begin
            all_parked = 1'b0;
            if (lvl_q[p]) fold_exp[TGT_W'(route_q[p])] = 1'b1;
         end
      end
   end

   assert_out_fold_R4: assert property (@(posedge clk) disable iff (rst)
      irq_q == fold_exp);

   assert_parked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      all_parked |-> irq_q == '0);

   assert_reset_out_R3: assert property (@(posedge clk)
      rst |=> irq_q == '0);
endmodule

// File: rtl/irq_slot_swizzle.sv
module irq_slot_swizzle #(
   parameter int unsigned NUM_LINES  = 4,
   parameter bit          SWIZZLE_EN = 1'b1
) (
   input  logic [7:0]                     dev_fn,
   input  logic [1:0]                     dev_pin,
   output logic [$clog2(NUM_LINES)-1:0]   dev_pirq
);
   localparam int unsigned LINE_W = $clog2(NUM_LINES);

   if (SWIZZLE_EN) begin : g_rotate
      logic [7:0] sum;
      // adding N-1 equals subtracting one modulo a power of two N
      assign sum      = {6'b0, dev_pin} + {3'b0, dev_fn[7:3]} + 8'(NUM_LINES - 1);
      assign dev_pirq = sum[LINE_W-1:0];

      always_comb begin
         if (dev_fn[7:3] == 5'd1)
            assert_slot_one_R9: assert (dev_pirq == LINE_W'(dev_pin));
      end
   end else begin : g_direct
      assign dev_pirq = LINE_W'(dev_pin);
   end
endmodule

// File: rtl/intline_router.sv
module intline_router
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 4,
   parameter int unsigned NUM_TARGETS = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BUS_BYTES   = 4,
   parameter int unsigned ROUTE_BASE  = 'h60,
   parameter bit          SWIZZLE_EN  = 1'b1,
   localparam int unsigned LINE_W     = $clog2(NUM_LINES)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_LINES-1:0]     pirq_lvl,
   input  logic                     cfg_wr_en,
   input  logic [ADDR_W-1:0]        cfg_wr_addr,
   input  logic [8*BUS_BYTES-1:0]   cfg_wr_data,
   input  logic [BUS_BYTES-1:0]     cfg_wr_be,
   input  logic [ADDR_W-1:0]        cfg_rd_addr,
   output logic [8*BUS_BYTES-1:0]   cfg_rd_data,
   input  logic [7:0]               dev_fn,
   input  logic [1:0]               dev_pin,
   output logic [LINE_W-1:0]        dev_pirq,
   output logic [NUM_TARGETS-1:0]   irq_out
);
   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (NUM_TARGETS < 2 || NUM_TARGETS > 256) begin : g_bad_targets
      $error("NUM_TARGETS must lie between 2 and 256");
   end
   if (BUS_BYTES < 1 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("BUS_BYTES must be a power of two");
   end
   if (ROUTE_BASE + NUM_LINES > (1 << ADDR_W)) begin : g_bad_base
      $error("routing bytes fall outside the address space");
   end
   if (NUM_LINES * NUM_TARGETS > 4096) begin : g_bad_map
      $error("level map too large");
   end

   route_t [NUM_LINES-1:0] route_q;
   route_t [NUM_LINES-1:0] route_d;
   logic                   route_wr;

   irq_route_regs #(
      .NUM_LINES  (NUM_LINES),
      .ADDR_W     (ADDR_W),
      .BUS_BYTES  (BUS_BYTES),
      .ROUTE_BASE (ROUTE_BASE)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_wr_en),
      .wr_addr  (cfg_wr_addr),
      .wr_data  (cfg_wr_data),
      .wr_be    (cfg_wr_be),
      .rd_addr  (cfg_rd_addr),
      .rd_data  (cfg_rd_data),
      .route_q  (route_q),
      .route_d  (route_d),
      .route_wr (route_wr)
   );

   irq_level_map #(
      .NUM_LINES   (NUM_LINES),
      .NUM_TARGETS (NUM_TARGETS)
   ) u_map (
      .clk      (clk),
      .rst      (rst),
      .lvl_in   (pirq_lvl),
      .route_q  (route_q),
      .route_d  (route_d),
      .route_wr (route_wr),
      .irq_q    (irq_out)
   );

   irq_slot_swizzle #(
      .NUM_LINES  (NUM_LINES),
      .SWIZZLE_EN (SWIZZLE_EN)
   ) u_swz (
      .dev_fn   (dev_fn),
      .dev_pin  (dev_pin),
      .dev_pirq (dev_pirq)
   );
endmodule

// File: tb/tb_intline_router.sv
module tb_intline_router;
   logic        clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        rst;
   logic [3:0]  lvl;
   logic        we;
   logic [7:0]  wa;
   logic [31:0] wd;
   logic [3:0]  wbe;
   logic [7:0]  ra;
   logic [31:0] rd;
   logic [7:0]  fn;
   logic [1:0]  pin;
   logic [1:0]  dpirq;
   logic [15:0] irq;

   intline_router dut (
      .clk(clk), .rst(rst), .pirq_lvl(lvl),
      .cfg_wr_en(we), .cfg_wr_addr(wa), .cfg_wr_data(wd), .cfg_wr_be(wbe),
      .cfg_rd_addr(ra), .cfg_rd_data(rd),
      .dev_fn(fn), .dev_pin(pin), .dev_pirq(dpirq), .irq_out(irq)
   );

   int checks = 0;
   int errors = 0;

   // behavioural reference: routing bytes and expected outputs
   int          m_route [4];
   logic [15:0] m_out;

   always @(posedge clk) begin
      if (rst) begin
         for (int p = 0; p < 4; p++) m_route[p] = 128;
         m_out = '0;
      end else begin
         if (we) begin
            for (int b = 0; b < 4; b++) begin
               int a;
               a = int'(wa & 8'hFC) + b;
               if (wbe[b] && a >= 'h60 && a < 'h64) m_route[a - 'h60] = int'(wd[8*b +: 8]);
            end
         end
         m_out = '0;
         for (int p = 0; p < 4; p++)
            if (lvl[p] && m_route[p] < 16) m_out[m_route[p]] = 1'b1;
      end
   end

   function automatic logic [31:0] exp_rd(input logic [7:0] addr);
      logic [31:0] v;
      v = '0;
      for (int b = 0; b < 4; b++) begin
         int a;
         a = int'(addr & 8'hFC) + b;
         if (a >= 'h60 && a < 'h64) v[8*b +: 8] = 8'(m_route[a - 'h60]);
      end
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // advance one cycle and compare against the model at the falling edge
   task automatic cyc();
      @(negedge clk);
      chk("R4 R5 per-cycle output", {16'h0, irq}, {16'h0, m_out});
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      wa = a; wd = d; wbe = be; we = 1'b1;
      cyc();
      we = 1'b0; wbe = '0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      ra = a;
      #1;
      chk(req, rd, exp);
      chk({req, " model"}, rd, exp_rd(a));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; lvl = '0; we = 1'b0; wa = '0; wd = '0; wbe = '0;
      ra = 8'h60; fn = '0; pin = '0;
      cyc(); cyc();
      chk("R3 reset outputs", {16'h0, irq}, 32'h0);
      rd_chk("R3 R1 reset routes", 8'h60, 32'h80808080);
      rst = 1'b0;

      // parked lines drive nothing
      lvl = 4'hF; cyc();
      chk("R2 parked lines", {16'h0, irq}, 32'h0);

      // full-word write while all lines high: rebuild
      wr(8'h60, 32'h05050A03, 4'hF);
      chk("R6 R7 rebuild full word", {16'h0, irq}, 32'h0428);
      rd_chk("R1 readback", 8'h60, 32'h05050A03);
      rd_chk("R1 unaligned read address", 8'h62, 32'h05050A03);

      lvl = 4'h0; cyc();
      chk("R5 all drop", {16'h0, irq}, 32'h0);
      lvl = 4'b0001; cyc();
      chk("R5 single rise", {16'h0, irq}, 32'h0008);
      lvl = 4'b0011; #1;
      chk("R5 not before edge", {16'h0, irq}, 32'h0008);
      cyc();
      chk("R5 second line", {16'h0, irq}, 32'h0408);

      // shared output: lines 2 and 3 both on output 5
      lvl = 4'b1100; cyc();
      chk("R4 shared both high", {16'h0, irq}, 32'h0020);
      lvl = 4'b1000; cyc();
      chk("R4 shared one high", {16'h0, irq}, 32'h0020);
      lvl = 4'b0000; cyc();
      chk("R4 shared both low", {16'h0, irq}, 32'h0);

      // partial byte enable: only line 1 to 15
      lvl = 4'b0011; cyc();
      wr(8'h60, 32'hFFFF0FFF, 4'b0010);
      chk("R7 R2 lane 1 only, target 15", {16'h0, irq}, 32'h8008);
      rd_chk("R7 other lanes kept", 8'h60, 32'h05050F03);

      // move an asserted line
      wr(8'h60, 32'h00000007, 4'b0001);
      chk("R6 move asserted line", {16'h0, irq}, 32'h8080);

      // boundary 16 and 0xFF park a line
      wr(8'h60, 32'h00000010, 4'b0001);
      chk("R2 value 16 parks", {16'h0, irq}, 32'h8000);
      wr(8'h60, 32'h0000FF00, 4'b0010);
      chk("R2 value 0xFF parks", {16'h0, irq}, 32'h0);

      // neighbouring offsets have no effect
      lvl = 4'b1100; cyc();
      wr(8'h64, 32'hFFFFFFFF, 4'hF);
      wr(8'h5C, 32'h00000000, 4'hF);
      cyc();
      chk("R8 foreign writes, output", {16'h0, irq}, 32'h0020);
      rd_chk("R8 foreign writes, routes", 8'h60, 32'h0505FF10);
      rd_chk("R1 empty word reads zero", 8'h64, 32'h0);

      // randomized traffic
      for (int i = 0; i < 400; i++) begin
         lvl = 4'($urandom);
         if ($urandom_range(7) == 0) begin
            logic [31:0] d;
            for (int b = 0; b < 4; b++)
               d[8*b +: 8] = ($urandom_range(2) == 0) ? 8'($urandom) : 8'($urandom_range(15));
            wr(8'h5C + 8'(4 * $urandom_range(2)), d, 4'($urandom));
         end else begin
            cyc();
         end
      end
      rd_chk("R1 R7 routes after traffic", 8'h60, exp_rd(8'h60));

      // slot rotation sweep
      for (int s = 0; s < 32; s++) begin
         for (int p = 0; p < 4; p++) begin
            fn  = {5'(s), 3'($urandom)};
            pin = 2'(p);
            #1;
            chk("R9 slot rotation", {30'h0, dpirq}, 32'((p + s + 3) % 4));
         end
      end

      // reset in the middle of activity
      lvl = 4'hF;
      wr(8'h60, 32'h01020304, 4'hF);
      rst = 1'b1; cyc();
      chk("R3 mid-run reset outputs", {16'h0, irq}, 32'h0);
      rd_chk("R3 mid-run reset routes", 8'h60, 32'h80808080);
      rst = 1'b0; cyc();
      chk("R3 R2 parked after reset", {16'h0, irq}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule